// File: doc/BRIEF.md
# Page-Mode EDO DRAM Access Controller

This block sits between a simple host request port and an asynchronous fast-page-mode DRAM with extended data out. It splits a 22-bit word address into an 11-bit row and an 11-bit column and drives them over one multiplexed address bus. The row is presented with the falling edge of the row strobe and the column with the falling edge of the column strobe. All strobe timing is counted in clock cycles. Each interval is a parameter, so one build can meet the memory's minimum widths, setup times and precharge times at any clock rate.

Once a row is open it stays open. Any later request to the same row is served as a page cycle that toggles only the column strobe. A request to another row first closes the row, waits out the row precharge and then opens the new row. Read data is captured a set number of clocks after the column strobe falls. Because the memory keeps its output valid past the rising column strobe, this sample point may fall after the strobe has already risen again. Each captured word is returned with a one-clock valid pulse.

Before the row-low limit is reached the controller closes the page on its own. It also closes the page when a refresh requester raises its request. It then grants the bus while every strobe is idle.

Top module: `edo_page_ctrl`

## Requirements
- R1: During and right after reset, both strobes, the write enable and the output enable are high (inactive). The read valid and refresh grant outputs are low.
- R2: Row bits are req_addr[21:11] and column bits are req_addr[10:0]. The row is on the address bus when the row strobe falls. The column strobe falls exactly T_RCD cycles later, carrying the column.
- R3: The column strobe stays low for exactly T_CAS cycles and high for at least T_CP cycles between two column cycles in one row. While the column strobe is low, the address and write enable do not change.
- R4: A write (req_write=1) has write enable low and the data bus driven (dq_oe=1) with the request data when the column strobe falls and for the whole low time. The output enable stays high throughout.
- R5: A read has write enable high and output enable low when the column strobe falls. The data bus is sampled RD_LAT cycles after that edge, with RD_LAT no larger than T_CAS+T_CP. rd_valid pulses for one clock with the stored word, and reads return in request order.
- R6: Consecutive requests to the open row are served without the row strobe rising.
- R7: A request to a different row raises the row strobe. The strobe stays high at least T_RP cycles before it falls again with the new row.
- R8: While refresh_req is high, the open row is closed and refresh_grant is raised only with both strobes high. No request is accepted while the grant is high, and the grant drops one cycle after refresh_req falls.
- R9: The row strobe is never held low for more than RAS_MAX_CYC consecutive cycles, even under a continuous stream of hits to one row.
- R10: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-clock pulse with returned read data |
| rd_data | output | 4 | Read data |
| refresh_req | input | 1 | Refresh requester wants the bus |
| refresh_grant | output | 1 | Bus is idle and handed to the refresh requester |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Write data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data bus from the memory |

## Verification
The bench sets T_RCD, T_CAS and T_CP to one cycle, T_RP to two and RD_LAT to two. Each read is therefore sampled on the same edge as the next column strobe falls, after its own column strobe has already risen. That edge case only works if the data hold beyond the strobe edge is relied on correctly. RAS_MAX_CYC is cut to 40 so that a burst of thirty same-row reads has to hit the forced page close and reopen the row within a short run.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFRESH,
    ST_RCD,
    ST_CAS,
    ST_OPEN,
    ST_RP
  } ctl_state_e;
endpackage

// File: rtl/edo_page_track.sv
module edo_page_track #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_stb,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_stb,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             hit
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_stb) begin
      open_q <= 1'b1;
      row_q  <= open_row;
    end else if (close_stb) begin
      open_q <= 1'b0;
    end
  end

  assign hit = open_q && (row_q == cmp_row);

  // a row is only closed when one is open
  assert_close_open_R7: assert property (@(posedge clk) disable iff (rst)
    close_stb |-> open_q);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int RAS_MAX_CYC = 4900,
  parameter int MARGIN      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_low,
  output logic force_close
);
  localparam int LIMIT = RAS_MAX_CYC - MARGIN;
  localparam int CW    = $clog2(RAS_MAX_CYC + 2);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || !ras_low) low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign force_close = (low_cnt >= CW'(LIMIT));

  assert_ras_window_R9: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= CW'(RAS_MAX_CYC));
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture #(
  parameter int LAT  = 2,
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  logic [LAT-1:0] pipe_q;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= launch;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[LAT-2:0], launch};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pipe_q[LAT-1];
      if (pipe_q[LAT-1]) rd_data <= dq_in;
    end
  end

  // page cycle spacing keeps at most one read waiting for its sample
  assert_one_in_flight_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(pipe_q) <= 1);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 11,
  parameter int DQ_W        = 4,
  parameter int T_RCD       = 1,
  parameter int T_CAS       = 1,
  parameter int T_CP        = 1,
  parameter int T_RP        = 2,
  parameter int RD_LAT      = 2,
  parameter int RAS_MAX_CYC = 4900
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]          req_wdata,
  output logic                     rd_valid,
  output logic [DQ_W-1:0]          rd_data,
  input  logic                     refresh_req,
  output logic                     refresh_grant,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DQ_W-1:0]          dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DQ_W-1:0]          dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_A    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_B    = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int MAXT   = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W  = $clog2(MAXT + 1);
  localparam int MARGIN = T_CAS + T_CP + 2;

  ctl_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;

  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DQ_W-1:0]  wd_q;

  logic             ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q, grant_q;
  logic [PIN_W-1:0] addr_q;
  logic [DQ_W-1:0]  dq_q;

  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;
  logic             hit, force_close, accept, close_now;
  logic             issue_col, nx_wr, launch_rd;
  logic [COL_W-1:0] nx_col;
  logic [DQ_W-1:0]  nx_wd;

  assign in_row   = req_addr[ADDR_W-1:COL_W];
  assign in_col   = req_addr[COL_W-1:0];
  assign cnt_done = (cnt_q == '0);

  // acceptance: from a closed bank, or as a page hit once precharge is done
  always_comb begin
    req_ready = 1'b0;
    if (state_q == ST_IDLE)
      req_ready = !refresh_req;
    else if (state_q == ST_OPEN)
      req_ready = cnt_done && !refresh_req && !force_close && hit;
  end
  assign accept = req_valid && req_ready;

  assign close_now = (state_q == ST_OPEN) && cnt_done &&
                     (refresh_req || force_close || (req_valid && !hit));

  // column source: latched request after row open, live request on a hit
  always_comb begin
    if (state_q == ST_OPEN) begin
      nx_col = in_col;
      nx_wr  = req_write;
      nx_wd  = req_wdata;
    end else begin
      nx_col = col_q;
      nx_wr  = wr_q;
      nx_wd  = wd_q;
    end
  end
  assign issue_col = ((state_q == ST_RCD) && cnt_done) ||
                     ((state_q == ST_OPEN) && accept);
  assign launch_rd = issue_col && !nx_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      grant_q <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
    end else begin
      if (issue_col) begin
        addr_q  <= PIN_W'(nx_col);
        cas_n_q <= 1'b0;
        we_n_q  <= !nx_wr;
        oe_n_q  <= nx_wr;
        dq_q    <= nx_wd;
        dq_oe_q <= nx_wr;
        cnt_q   <= CNT_W'(T_CAS - 1);
        state_q <= ST_CAS;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (refresh_req) begin
              grant_q <= 1'b1;
              state_q <= ST_REFRESH;
            end else if (req_valid) begin
              col_q   <= in_col;
              wr_q    <= req_write;
              wd_q    <= req_wdata;
              addr_q  <= PIN_W'(in_row);
              ras_n_q <= 1'b0;
              cnt_q   <= CNT_W'(T_RCD - 1);
              state_q <= ST_RCD;
            end
          end
          ST_REFRESH: begin
            if (!refresh_req) begin
              grant_q <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          ST_RCD: begin
            cnt_q <= cnt_q - 1'b1;
          end
          ST_CAS: begin
            if (cnt_done) begin
              cas_n_q <= 1'b1;
              we_n_q  <= 1'b1;
              dq_oe_q <= 1'b0;
              cnt_q   <= CNT_W'(T_CP - 1);
              state_q <= ST_OPEN;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_OPEN: begin
            if (!cnt_done) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (close_now) begin
              ras_n_q <= 1'b1;
              oe_n_q  <= 1'b1;
              cnt_q   <= CNT_W'(T_RP - 1);
              state_q <= ST_RP;
            end
          end
          ST_RP: begin
            if (cnt_done) state_q <= ST_IDLE;
            else          cnt_q   <= cnt_q - 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  edo_page_track #(.ROW_W(ROW_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .open_stb  ((state_q == ST_IDLE) && accept),
    .open_row  (in_row),
    .close_stb (close_now),
    .cmp_row   (in_row),
    .hit       (hit)
  );

  edo_ras_guard #(.RAS_MAX_CYC(RAS_MAX_CYC), .MARGIN(MARGIN)) u_guard (
    .clk         (clk),
    .rst         (rst),
    .ras_low     (!ras_n_q),
    .force_close (force_close)
  );

  edo_rd_capture #(.LAT(RD_LAT), .DQ_W(DQ_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch_rd),
    .dq_in    (dram_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign dram_ras_n    = ras_n_q;
  assign dram_cas_n    = cas_n_q;
  assign dram_we_n     = we_n_q;
  assign dram_oe_n     = oe_n_q;
  assign dram_addr     = addr_q;
  assign dram_dq_out   = dq_q;
  assign dram_dq_oe    = dq_oe_q;
  assign refresh_grant = grant_q;

  assert_cas_inside_ras_R10: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  assert_rcd_before_cas_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> $past(!dram_ras_n));

  assert_col_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && $past(!dram_cas_n)) |-> ($stable(dram_addr) && $stable(dram_we_n)));

  assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && !dram_we_n) |-> (dram_dq_oe && dram_oe_n));

  assert_grant_idle_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_grant |-> (dram_ras_n && dram_cas_n && !req_ready));

  assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |=> dram_ras_n);
endmodule

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;
  localparam int T_RCD = 1, T_CAS = 1, T_CP = 1, T_RP = 2, RD_LAT = 2, RAS_MAX = 40;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid, refresh_grant;
  logic [3:0]  rd_data;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dram_dq_in = '0;

  int checks = 0, errors = 0;
  logic [3:0] shadow [int];
  logic [3:0] mem [int];
  logic [3:0] exp_q [$];

  always #10 clk = ~clk;

  edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                  .RD_LAT(RD_LAT), .RAS_MAX_CYC(RAS_MAX)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
    .refresh_grant(refresh_grant), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: issue one request and push the expected read word
  task automatic issue(input logic wr, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr) shadow[int'(a)] = d;
    else    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // memory model and pin monitor
  logic        ras_prev = 1'b1, cas_prev = 1'b1, first_col = 1'b0;
  int          ras_low_run = 0, ras_high_run = 1000, cas_low_run = 0, cas_high_run = 0;
  int          ras_falls = 0, max_ras_low = 0;
  logic [10:0] row_lat = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!dram_cas_n) check(!dram_ras_n, "R10 cas low inside ras", dram_ras_n, 0);
      if (!dram_ras_n && ras_prev) begin
        check(ras_high_run >= T_RP, "R7 row precharge", ras_high_run, T_RP);
        ras_falls++; row_lat = dram_addr; first_col = 1'b1;
      end
      if (!dram_cas_n && cas_prev) begin
        if (first_col) check(ras_low_run == T_RCD, "R2 row to column delay", ras_low_run, T_RCD);
        else           check(cas_high_run >= T_CP, "R3 column precharge", cas_high_run, T_CP);
        first_col = 1'b0;
        if (!dram_we_n) begin
          check(dram_dq_oe && dram_oe_n, "R4 write drive", {dram_dq_oe, dram_oe_n}, 3);
          mem[int'({row_lat, dram_addr})] = dram_dq_out;
        end else begin
          check(!dram_oe_n, "R5 read output enable", dram_oe_n, 0);
          dram_dq_in = mem.exists(int'({row_lat, dram_addr})) ? mem[int'({row_lat, dram_addr})] : 4'h0;
        end
      end
      if (dram_cas_n && !cas_prev) check(cas_low_run == T_CAS, "R3 column low width", cas_low_run, T_CAS);
      if (dram_ras_n && !ras_prev) check(ras_low_run <= RAS_MAX, "R9 row low window", ras_low_run, RAS_MAX);
      if (dram_ras_n) begin ras_high_run++; ras_low_run = 0; end
      else            begin ras_low_run++; ras_high_run = 0; end
      if (ras_low_run > max_ras_low) max_ras_low = ras_low_run;
      if (dram_cas_n) begin cas_high_run++; cas_low_run = 0; end
      else            begin cas_low_run++; cas_high_run = 0; end
      ras_prev = dram_ras_n; cas_prev = dram_cas_n;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected read", rd_data, -1);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R5 read data", rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5 watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [10:0] ROW_A = 11'h005, ROW_B = 11'h7FF, ROW_C = 11'h000;

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    check(!rd_valid && !refresh_grant, "R1 outputs low in reset", {rd_valid, refresh_grant}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && !rd_valid, "R1 idle after reset",
          {dram_ras_n, dram_cas_n, rd_valid}, 6);

    // R6: page hits in one row, including column extremes
    f0 = ras_falls;
    issue(1'b1, {ROW_A, 11'h000}, 4'hA);
    issue(1'b1, {ROW_A, 11'h7FF}, 4'h5);
    issue(1'b0, {ROW_A, 11'h000}, 4'h0);
    issue(1'b0, {ROW_A, 11'h7FF}, 4'h0);
    issue(1'b1, {ROW_A, 11'h123}, 4'hF);
    issue(1'b0, {ROW_A, 11'h123}, 4'h0);
    repeat (2) @(negedge clk); #1;
    check(ras_falls - f0 == 1, "R6 hits keep row open", ras_falls - f0, 1);

    // R7: row miss reopens, then back to row A
    f0 = ras_falls;
    issue(1'b1, {ROW_B, 11'h7FF}, 4'h3);
    issue(1'b0, {ROW_A, 11'h7FF}, 4'h0);
    issue(1'b0, {ROW_B, 11'h7FF}, 4'h0);
    repeat (2) @(negedge clk); #1;
    check(ras_falls - f0 == 3, "R7 each miss reopens row", ras_falls - f0, 3);

    // R8: refresh closes the open row and blocks requests
    @(negedge clk); refresh_req = 1'b1;
    do begin @(negedge clk); #1; end while (!refresh_grant);
    check(dram_ras_n && dram_cas_n, "R8 strobes idle at grant", {dram_ras_n, dram_cas_n}, 3);
    check(ras_high_run >= T_RP, "R8 precharge before grant", ras_high_run, T_RP);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {ROW_B, 11'h7FF};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(!req_ready, "R8 no accept while granted", req_ready, 0);
    end
    req_valid = 1'b0; refresh_req = 1'b0;
    @(negedge clk); #1;
    check(!refresh_grant, "R8 grant drops", refresh_grant, 0);
    issue(1'b0, {ROW_B, 11'h7FF}, 4'h0);

    // R9: long hit stream forces the page closed
    f0 = ras_falls;
    issue(1'b1, {ROW_C, 11'h001}, 4'h9);
    for (int i = 0; i < 30; i++) issue(1'b0, {ROW_C, 11'h001}, 4'h0);
    repeat (6) @(negedge clk); #1;
    check(ras_falls - f0 >= 2, "R9 forced reopen under hits", ras_falls - f0, 2);
    check(max_ras_low <= RAS_MAX, "R9 longest row low", max_ras_low, RAS_MAX);
    check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule